// File: doc/BRIEF.md
# Dual Fetch Buffer Enqueue Unit

The block sits between instruction fetch and the tail of an instruction queue. It holds fetched instruction pairs in two two-entry buffers used in ping-pong order. Each fetch packet carries two 16-bit instructions and the address of the first. The second instruction's address is the first plus two. A packet is written only into a buffer that is completely empty. The fetch stage is stalled while both buffers still hold at least one live instruction.

Every cycle the unit offers the oldest live instructions of one buffer to the queue through two tail slots. It empties that buffer fully before it turns to the other one. A built-in static predictor recognises the conditional branch opcode and predicts it taken when its displacement is negative. When such a branch is enqueued, the unit pulses a redirect with the computed target. It also discards every younger instruction it still holds: the rest of the branch's own buffer and the whole alternate buffer.

Top module: `fbq_enqueue`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) both buffers are empty, `fetch_stall` is low and no instruction is enqueued.
- R2: `fetch_stall` is high exactly when each buffer holds at least one live instruction. A packet offered with `fetch_valid` while `fetch_stall` is high is dropped.
- R3: An accepted packet is first offered for enqueue in the cycle after it is written. Slot 0 carries address `fetch_pc` and slot 1 carries `fetch_pc + 2`, modulo 2^16.
- R4: Instructions leave in program order. Tail0 carries the oldest live instruction and tail1 the next one. The unit drains one buffer completely before it takes anything from the other, and buffers are drained in the order they were filled.
- R5: `enq_rdy[0]` accepts tail0 and `enq_rdy[1]` accepts tail1. Tail1 is enqueued only when both ready bits are high. With only `enq_rdy[0]` high, only the oldest live instruction is enqueued. With only `enq_rdy[1]` high, nothing is enqueued.
- R6: An instruction is a branch when bits [15:12] equal 4'hB. Its displacement is bits [7:0], read as two's complement. It is predicted taken exactly when bit 7 is set. `enq_ptkn[k]` is high when the instruction enqueued on tail k is predicted taken.
- R7: When a predicted-taken branch is enqueued, `redir_vld` pulses in that same cycle. `redir_pc` equals the branch address plus 2 plus twice the displacement, modulo 2^16.
- R8: When the oldest live instruction of a buffer is a predicted-taken branch, it goes out alone on tail0. The other instruction of its buffer and all contents of the alternate buffer are discarded and never enqueued.
- R9: When the taken branch is enqueued on tail1, the older instruction on tail0 is enqueued normally and only the alternate buffer is discarded.
- R10: A packet offered in a redirect cycle is dropped, so in the cycle after a redirect nothing is enqueued.
- R11: A branch with non-negative displacement, or any other instruction, causes no redirect and discards nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch packet present |
| fetch_pc | input | 16 | Address of the packet's first instruction |
| fetch_ins0 | input | 16 | Older instruction of the packet |
| fetch_ins1 | input | 16 | Younger instruction of the packet |
| fetch_stall | output | 1 | No empty buffer; fetch must hold |
| enq_rdy | input | 2 | Queue can accept tail0 (bit 0) and tail1 (bit 1) |
| enq_vld | output | 2 | Instruction enqueued on tail0 / tail1 this cycle |
| enq_ins0 | output | 16 | Instruction on tail0 |
| enq_pc0 | output | 16 | Address of tail0 instruction |
| enq_ins1 | output | 16 | Instruction on tail1 |
| enq_pc1 | output | 16 | Address of tail1 instruction |
| enq_ptkn | output | 2 | Predicted-taken flag per tail slot |
| redir_vld | output | 1 | Redirect pulse for a predicted-taken branch |
| redir_pc | output | 16 | Redirect target |

## Verification
Two events can fall in the same cycle: a redirect with its squash, and the arrival of a new fetch packet. A third case is a taken branch landing on tail1 while only tail0 is ready. The sweep covers every placement of plain, forward-branch and backward-branch instructions across the first two packets, crossed with four ready patterns that include tail1-only readiness. The fetch port keeps offering packets, so packets arrive during redirects and during stalls. A bench model holds the pending packets as an ordered list. Each cycle it judges stall, both tail slots, the prediction flags and the redirect target against that list.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
    localparam int NUM_BUF  = 2;
    localparam int NUM_SLOT = 2;

    typedef logic [NUM_SLOT-1:0] slot_mask_t;
endpackage

// File: rtl/fbq_bpred.sv
// Static predictor for one buffered instruction: backward taken, forward not.
module fbq_bpred #(
    parameter int          INS_W  = 16,
    parameter int          PC_W   = 16,
    parameter int          OPC_W  = 4,
    parameter int          OFF_W  = 8,
    parameter logic [3:0]  BR_OPC = 4'hB
) (
    input  logic [INS_W-1:0] ins_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             taken_o,
    output logic [PC_W-1:0]  tgt_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [OPC_W-1:0] opc;
    logic [OFF_W-1:0] disp;
    logic [PC_W-1:0]  disp_ext;
    logic [PC_W-1:0]  disp_x2;

    always_comb begin
        opc      = ins_i[INS_W-1 -: OPC_W];
        disp     = ins_i[OFF_W-1:0];
        disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
        disp_x2  = {disp_ext[PC_W-2:0], 1'b0};
        taken_o  = (opc == BR_OPC[OPC_W-1:0]) && disp[OFF_W-1];
        tgt_o    = pc_i + PC_W'(2) + disp_x2;
    end
endmodule

// File: rtl/fbq_pick.sv
// Slot selection, squash and redirect decisions for the buffer being drained.
module fbq_pick
    import fbq_pkg::*;
(
    input  slot_mask_t vld_i,
    input  slot_mask_t tkn_i,
    input  slot_mask_t rdy_i,
    output logic       first_o,
    output slot_mask_t fire_o,
    output slot_mask_t clr_o,
    output logic       redir_o,
    output logic       redir_slot_o
);
    logic has0, has1, head_tkn;

    always_comb begin
        first_o  = ~vld_i[0];
        has0     = |vld_i;
        has1     = (&vld_i) & ~tkn_i[0];
        head_tkn = tkn_i[first_o];

        fire_o[0] = has0 & rdy_i[0];
        fire_o[1] = has1 & rdy_i[0] & rdy_i[1];

        clr_o = '0;
        if (fire_o[0]) clr_o[first_o] = 1'b1;
        if (fire_o[1]) clr_o[1]       = 1'b1;

        redir_o      = 1'b0;
        redir_slot_o = 1'b0;
        if (fire_o[0] && head_tkn) begin
            redir_o      = 1'b1;
            redir_slot_o = first_o;
            clr_o        = '1;
        end else if (fire_o[1] && tkn_i[1]) begin
            redir_o      = 1'b1;
            redir_slot_o = 1'b1;
        end
    end
endmodule

// File: rtl/fbq_enqueue.sv
module fbq_enqueue
    import fbq_pkg::*;
#(
    parameter int         INS_W  = 16,
    parameter int         PC_W   = 16,
    parameter int         OPC_W  = 4,
    parameter int         OFF_W  = 8,
    parameter logic [3:0] BR_OPC = 4'hB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [INS_W-1:0] fetch_ins0,
    input  logic [INS_W-1:0] fetch_ins1,
    output logic             fetch_stall,
    input  logic [1:0]       enq_rdy,
    output logic [1:0]       enq_vld,
    output logic [INS_W-1:0] enq_ins0,
    output logic [PC_W-1:0]  enq_pc0,
    output logic [INS_W-1:0] enq_ins1,
    output logic [PC_W-1:0]  enq_pc1,
    output logic [1:0]       enq_ptkn,
    output logic             redir_vld,
    output logic [PC_W-1:0]  redir_pc
);
    localparam int PC_STEP = (INS_W + 7) / 8;

    typedef struct packed {
        logic                                    sel;
        logic [NUM_BUF-1:0][NUM_SLOT-1:0]        vld;
        logic [NUM_BUF-1:0][NUM_SLOT-1:0][INS_W-1:0] ins;
        logic [NUM_BUF-1:0][NUM_SLOT-1:0][PC_W-1:0]  pc;
    } state_t;

    state_t st_q, st_d;

    logic                               cur, alt, wr_buf, accept;
    logic [NUM_SLOT-1:0][INS_W-1:0]     cur_ins;
    logic [NUM_SLOT-1:0][PC_W-1:0]      cur_pc;
    slot_mask_t                         tkn, fire, clr;
    logic [NUM_SLOT-1:0][PC_W-1:0]      tgt;
    logic                               first, redir, redir_slot;

    assign cur     = st_q.sel;
    assign alt     = ~st_q.sel;
    assign cur_ins = st_q.ins[cur];
    assign cur_pc  = st_q.pc[cur];

    generate
        for (genvar s = 0; s < NUM_SLOT; s++) begin : g_pred
            fbq_bpred #(
                .INS_W (INS_W),
                .PC_W  (PC_W),
                .OPC_W (OPC_W),
                .OFF_W (OFF_W),
                .BR_OPC(BR_OPC)
            ) u_pred (
                .ins_i  (cur_ins[s]),
                .pc_i   (cur_pc[s]),
                .taken_o(tkn[s]),
                .tgt_o  (tgt[s])
            );
        end
    endgenerate

    fbq_pick u_pick (
        .vld_i       (st_q.vld[cur]),
        .tkn_i       (tkn),
        .rdy_i       (enq_rdy),
        .first_o     (first),
        .fire_o      (fire),
        .clr_o       (clr),
        .redir_o     (redir),
        .redir_slot_o(redir_slot)
    );

    always_comb begin
        fetch_stall = (|st_q.vld[0]) & (|st_q.vld[1]);
        enq_vld     = fire;
        enq_ins0    = cur_ins[first];
        enq_pc0     = cur_pc[first];
        enq_ins1    = cur_ins[1];
        enq_pc1     = cur_pc[1];
        enq_ptkn[0] = fire[0] & tkn[first];
        enq_ptkn[1] = fire[1] & tkn[1];
        redir_vld   = redir;
        redir_pc    = tgt[redir_slot];
    end

    always_comb begin
        st_d          = st_q;
        st_d.vld[cur] = st_q.vld[cur] & ~clr;
        if (redir) st_d.vld[alt] = '0;

        accept = fetch_valid & ~fetch_stall & ~redir;
        wr_buf = (|st_q.vld[cur]) ? alt : cur;
        if (accept) begin
            st_d.vld[wr_buf]    = '1;
            st_d.ins[wr_buf][0] = fetch_ins0;
            st_d.ins[wr_buf][1] = fetch_ins1;
            st_d.pc[wr_buf][0]  = fetch_pc;
            st_d.pc[wr_buf][1]  = fetch_pc + PC_W'(PC_STEP);
        end

        if ((st_d.vld[cur] == '0) && (st_d.vld[alt] != '0)) st_d.sel = alt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_TAIL_ORDER: assert property (@(posedge clk) disable iff (rst)
        enq_vld[1] |-> enq_vld[0]);                                  // R5
    AST_TAIL1_BOTH_READY: assert property (@(posedge clk) disable iff (rst)
        enq_vld[1] |-> (&enq_rdy));                                  // R5
    AST_REDIR_ON_ENQ: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> enq_vld[0]);                                   // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        redir_vld |=> (!fetch_stall && !enq_vld[0]));                // R10
    AST_TAKEN_GOES_ALONE: assert property (@(posedge clk) disable iff (rst)
        !(enq_vld[1] && enq_ptkn[0]));                               // R8
    AST_DRAIN_BEFORE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld[st_q.sel] == '0) |-> (st_q.vld[~st_q.sel] == '0)); // R4
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall && !enq_vld[0]) |=> fetch_stall);               // R2
endmodule

// File: tb/fbq_enqueue_test.sv
`timescale 1ns/1ps
module fbq_enqueue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0, fetch_ins0 = '0, fetch_ins1 = '0;
    logic        fetch_stall;
    logic [1:0]  enq_rdy = '0, enq_vld, enq_ptkn;
    logic [15:0] enq_ins0, enq_pc0, enq_ins1, enq_pc1, redir_pc;
    logic        redir_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model: ordered list of pending packets, head at index 0
    int          pk_n;
    logic [15:0] m_ins [2][2];
    logic [15:0] m_pc  [2][2];
    logic [1:0]  m_rem [2];
    bit          after_redir;
    bit          first_step;

    always #5 clk = ~clk;

    fbq_enqueue uut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_ins0(fetch_ins0), .fetch_ins1(fetch_ins1), .fetch_stall(fetch_stall),
        .enq_rdy(enq_rdy), .enq_vld(enq_vld), .enq_ins0(enq_ins0), .enq_pc0(enq_pc0),
        .enq_ins1(enq_ins1), .enq_pc1(enq_pc1), .enq_ptkn(enq_ptkn),
        .redir_vld(redir_vld), .redir_pc(redir_pc)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic bit is_tkn(input logic [15:0] ins);
        return (ins[15:12] == 4'hB) && ins[7];
    endfunction

    function automatic logic [15:0] br_target(input logic [15:0] pc, input logic [15:0] ins);
        int disp;
        disp = (ins[7] ? int'(ins[7:0]) - 256 : int'(ins[7:0]));
        return 16'(int'(pc) + 2 + 2 * disp);
    endfunction

    function automatic logic [15:0] mk_ins(input int kind, input int tag);
        case (kind)
            0:       return {4'h1, 4'(tag), 8'h3C};
            1:       return {4'hB, 4'(tag), 8'h05 + 8'(tag)};
            default: return {4'hB, 4'(tag), (tag % 2 == 1) ? 8'h80 : 8'hF0 + 8'(tag % 8)};
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fetch_valid = 1'b0; enq_rdy = 2'b00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        pk_n = 0; after_redir = 1'b0; first_step = 1'b1;
        for (int b = 0; b < 2; b++) m_rem[b] = 2'b00;
    endtask

    task automatic step(input bit fv, input logic [15:0] pc, input logic [15:0] i0,
                        input logic [15:0] i1, input logic [1:0] rdy);
        bit e_stall, e0, e1, er, f;
        logic [15:0] epc;
        string tag;
        fetch_valid = fv; fetch_pc = pc; fetch_ins0 = i0; fetch_ins1 = i1; enq_rdy = rdy;
        #1;
        e_stall = (pk_n == 2);
        f   = (pk_n > 0) ? ~m_rem[0][0] : 1'b0;
        e0  = (pk_n > 0) && rdy[0];
        e1  = (pk_n > 0) && (m_rem[0] == 2'b11) && !is_tkn(m_ins[0][0]) && rdy[0] && rdy[1];
        er  = 1'b0; epc = '0; tag = "R5";
        if (e0 && is_tkn(m_ins[0][f])) begin
            er = 1'b1; epc = br_target(m_pc[0][f], m_ins[0][f]); tag = "R8";
        end else if (e1 && is_tkn(m_ins[0][1])) begin
            er = 1'b1; epc = br_target(m_pc[0][1], m_ins[0][1]); tag = "R9";
        end
        if (after_redir) tag = "R10";
        if (first_step)  tag = "R1";

        chk(first_step ? "R1" : "R2", 32'(fetch_stall), 32'(e_stall));
        chk(tag, 32'(enq_vld), 32'({e1, e0}));
        if (e0) begin
            chk("R3", 32'(enq_pc0), 32'(m_pc[0][f]));
            chk("R4", 32'(enq_ins0), 32'(m_ins[0][f]));
        end
        if (e1) begin
            chk("R3", 32'(enq_pc1), 32'(m_pc[0][1]));
            chk("R4", 32'(enq_ins1), 32'(m_ins[0][1]));
        end
        chk("R6", 32'(enq_ptkn), 32'({e1 && is_tkn(m_ins[0][1]), e0 && is_tkn(m_ins[0][f])}));
        chk(er ? "R7" : "R11", 32'(redir_vld), 32'(er));
        if (er) chk("R7", 32'(redir_pc), 32'(epc));

        if (e0) m_rem[0][f] = 1'b0;
        if (e1) m_rem[0][1] = 1'b0;
        if (er) begin
            m_rem[0] = 2'b00;
            pk_n = (pk_n > 0) ? 1 : 0;
        end
        if (fv && !e_stall && !er) begin
            m_ins[pk_n][0] = i0; m_ins[pk_n][1] = i1;
            m_pc[pk_n][0]  = pc; m_pc[pk_n][1]  = pc + 16'd2;
            m_rem[pk_n]    = 2'b11;
            pk_n++;
        end
        if (pk_n > 0 && m_rem[0] == 2'b00) begin
            m_ins[0] = m_ins[1]; m_pc[0] = m_pc[1]; m_rem[0] = m_rem[1];
            m_rem[1] = 2'b00;
            pk_n--;
        end
        after_redir = er;
        first_step  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int ka = 0; ka < 9; ka++) begin
            for (int kb = 0; kb < 9; kb++) begin
                for (int rp = 0; rp < 4; rp++) begin
                    logic [15:0] base;
                    base = (rp == 3) ? 16'hFFF8 : 16'(16'h0040 * (ka + 1) + 16'h0400 * kb);
                    do_reset();
                    step(1'b0, '0, '0, '0, 2'b11);
                    for (int c = 0; c < 11; c++) begin
                        int k;
                        bit fv;
                        logic [1:0] rdy;
                        k   = (c == 0) ? ka : (c == 1) ? kb : (c + ka + kb) % 9;
                        fv  = (c < 2) || (c % 3 != 2);
                        rdy = 2'((c * (rp + 1) + rp) % 4);
                        step(fv, 16'(base + 16'(4 * c)),
                             mk_ins(k % 3, 2 * c), mk_ins(k / 3, 2 * c + 1), rdy);
                    end
                end
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule